// File: doc/BRIEF.md
# Event Timer Global Register Block

This block is the top-level register file of a multi-channel event timer. It owns the free-running 64-bit main counter, a read-only capability word, a two-bit global control word (run enable and legacy routing), and a per-channel interrupt status word. It decodes a 1 KiB register window and accepts 32-bit and 64-bit accesses. Address bit 2 picks the upper half of a 64-bit register.

Accesses from 0x100 upward belong to the timer channels. The block turns them into a channel index, a local offset and a one-cycle read or write strobe, and passes the channel's read data back unchanged. The channels raise status bits through fire inputs. Software clears those bits by writing ones. Each cleared bit also produces a one-cycle clear pulse so that the interrupt path can drop the line.

The main counter counts tick-enable cycles only while the run bit is set. When the block is halted, software can load the counter, and the loaded value becomes the starting count at the next enable.

Top module: `evt_regblk`

## Requirements
- R1: A read at offset 0x000 returns the capability word. Bits 7:0 hold revision 1, bits 12:8 hold the channel count minus one, bit 13 and bit 15 are 1, bits 31:16 hold VENDOR_ID, and bits 63:32 hold PERIOD_FS. Writes to this offset change nothing.
- R2: At offset 0x010, bit 0 (run enable) drives `glb_en` and bit 1 (legacy routing) drives `legacy_rt`. No other bit is writable, and all other bits read as 0.
- R3: While `glb_en` is 1, the main counter (offset 0x0F0) grows by one in every cycle in which `tick_en` is 1. It holds its value in cycles in which `tick_en` is 0.
- R4: A counter write while `glb_en` is 1 leaves the running count unaffected. Clearing the run bit then captures the running count as the halted value.
- R5: While halted, counter reads return a frozen value, and `tick_en` has no effect. A value written while halted becomes the starting count on the next enable.
- R6: A pulse on `ch_fire[i]` sets status bit i (offset 0x020). A write of 1 to a set bit clears it and pulses `ch_clr[i]` in the same cycle. Writing 0, or writing to the upper half at 0x024, has no effect.
- R7: If `ch_fire[i]` and a clear of bit i fall in the same cycle, the bit stays set and `ch_clr[i]` stays low.
- R8: A 32-bit write (`req_wide`=0) changes only the half selected by address bit 2. A 64-bit access at an address with bit 2 set is treated as an upper-half access and takes `req_wdata[31:0]`. Reads shift the selected half into bits 31:0, and a 32-bit read returns 0 in bits 63:32.
- R9: An access at 0x100..0x3FF gives `ch_idx` = (addr-0x100)/0x20 and `ch_off` = addr[4:0]. It pulses `ch_wr` or `ch_rd` for that cycle, and a read returns `ch_rdata`.
- R10: A channel access whose index is at or above the channel count raises no strobe and reads as 0.
- R11: All other offsets below 0x100 read as 0, and writes to them change no register.
- R12: After reset, the counter, the control bits and the status bits are all 0.
- R13: The NUM_TIMERS parameter is clamped to the range 3..32. The clamped count sets the status and strobe widths and the capability count field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Counter advance qualifier |
| req_wr | input | 1 | Register write strobe |
| req_rd | input | 1 | Register read strobe |
| req_addr | input | 10 | Byte address in the window |
| req_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit |
| req_wdata | input | 64 | Write data |
| req_rdata | output | 64 | Read data (0 when no read) |
| ch_fire | input | NCH | Per-channel status set pulses |
| ch_rdata | input | 64 | Read data from the addressed channel |
| ch_idx | output | 5 | Addressed channel index |
| ch_off | output | 5 | Offset inside the channel slot |
| ch_wr | output | 1 | Channel write strobe |
| ch_rd | output | 1 | Channel read strobe |
| ch_clr | output | NCH | Status clear pulses |
| int_status | output | NCH | Status bits |
| glb_en | output | 1 | Run enable |
| legacy_rt | output | 1 | Legacy routing select |

## Verification
Two things can land in the same cycle: a channel fire and a software write-1 clear of the same status bit. The bench drives a fire pulse in the cycle of the clearing write. It then expects the bit to stay set and no clear pulse for that channel, while other bits in the same write clear normally. A second case is a counter write while the counter is running and ticking: the reference model must show the live count stepping as if no write had happened.

// File: rtl/evt_pkg.sv
package evt_pkg;

    localparam int ADDR_W = 10;

    localparam logic [ADDR_W-1:0] OFF_CAP  = 10'h000;
    localparam logic [ADDR_W-1:0] OFF_CTRL = 10'h010;
    localparam logic [ADDR_W-1:0] OFF_STAT = 10'h020;
    localparam logic [ADDR_W-1:0] OFF_CNT  = 10'h0F0;

    localparam logic [4:0] CHAN_BASE_SLOT = 5'd8;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_CAP,
        RG_CTRL,
        RG_STAT,
        RG_CNT,
        RG_CHAN
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e   sel;
        logic       hi;
        logic [4:0] ch_idx;
        logic [4:0] ch_off;
        logic       ch_ok;
    } dec_t;

    function automatic int clamp_ch(input int n);
        if (n < 3)  return 3;
        if (n > 32) return 32;
        return n;
    endfunction

    function automatic logic [63:0] cap_word(input int nch,
                                             input logic [15:0] vid,
                                             input logic [31:0] per_fs);
        logic [63:0] w;
        w        = '0;
        w[7:0]   = 8'd1;
        w[12:8]  = 5'(nch - 1);
        w[13]    = 1'b1;
        w[15]    = 1'b1;
        w[31:16] = vid;
        w[63:32] = per_fs;
        return w;
    endfunction

    // Update only the half that the access selects.
    function automatic logic [63:0] merge_half(input logic [63:0] old,
                                               input logic [63:0] wd,
                                               input logic        hi,
                                               input logic        wide);
        if (hi)   return {wd[31:0], old[31:0]};
        if (wide) return wd;
        return {old[63:32], wd[31:0]};
    endfunction

    function automatic logic [63:0] read_half(input logic [63:0] v,
                                              input logic        hi,
                                              input logic        wide);
        logic [63:0] r;
        r = hi ? {32'd0, v[63:32]} : v;
        if (!wide) r[63:32] = 32'd0;
        return r;
    endfunction

endpackage

// File: rtl/evt_addr_dec.sv
module evt_addr_dec
    import evt_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);
    localparam logic [5:0] NCH_L = 6'(NCH);

    logic [4:0]        rel;
    logic [ADDR_W-1:0] base;

    assign rel  = addr[9:5] - CHAN_BASE_SLOT;
    assign base = {addr[9:3], 1'b0, addr[1:0]};

    always_comb begin
        dec.sel    = RG_NONE;
        dec.hi     = addr[2];
        dec.ch_idx = rel;
        dec.ch_off = addr[4:0];
        dec.ch_ok  = 1'b0;
        if (addr[9:8] != 2'b00) begin
            dec.sel   = RG_CHAN;
            dec.ch_ok = ({1'b0, rel} < NCH_L);
        end else begin
            case (base)
                OFF_CAP:  dec.sel = RG_CAP;
                OFF_CTRL: dec.sel = RG_CTRL;
                OFF_STAT: dec.sel = RG_STAT;
                OFF_CNT:  dec.sel = RG_CNT;
                default:  dec.sel = RG_NONE;
            endcase
        end
    end
endmodule

// File: rtl/evt_main_ctr.sv
module evt_main_ctr
    import evt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        run,
    input  logic        run_rise,
    input  logic        run_fall,
    input  logic        tick_en,
    input  logic        ld,
    input  logic        ld_hi,
    input  logic        ld_wide,
    input  logic [63:0] ld_data,
    output logic [63:0] cnt_view,
    output logic [63:0] cnt_live,
    output logic [63:0] cnt_hold
);
    logic [63:0] live_nxt;

    assign live_nxt = cnt_live + {63'd0, run & tick_en};

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_live <= '0;
            cnt_hold <= '0;
        end else begin
            cnt_live <= run_rise ? cnt_hold : live_nxt;
            if (run_fall)
                cnt_hold <= live_nxt;
            else if (ld)
                cnt_hold <= merge_half(cnt_hold, ld_data, ld_hi, ld_wide);
        end
    end

    assign cnt_view = run ? cnt_live : cnt_hold;
endmodule

// File: rtl/evt_stat.sv
module evt_stat #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] clr_req,
    input  logic [NCH-1:0] fire,
    output logic [NCH-1:0] status,
    output logic [NCH-1:0] clr_pulse
);
    // A new event in the clearing cycle wins over the clear.
    assign clr_pulse = clr_req & status & ~fire;

    always_ff @(posedge clk) begin
        if (rst) status <= '0;
        else     status <= (status & ~clr_pulse) | fire;
    end
endmodule

// File: rtl/evt_regblk.sv
module evt_regblk
    import evt_pkg::*;
#(
    parameter int          NUM_TIMERS = 4,
    parameter logic [15:0] VENDOR_ID  = 16'h1E5A,
    parameter logic [31:0] PERIOD_FS  = 32'd10000000
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                tick_en,
    input  logic                                req_wr,
    input  logic                                req_rd,
    input  logic [9:0]                          req_addr,
    input  logic                                req_wide,
    input  logic [63:0]                         req_wdata,
    output logic [63:0]                         req_rdata,
    input  logic [clamp_ch(NUM_TIMERS)-1:0]     ch_fire,
    input  logic [63:0]                         ch_rdata,
    output logic [4:0]                          ch_idx,
    output logic [4:0]                          ch_off,
    output logic                                ch_wr,
    output logic                                ch_rd,
    output logic [clamp_ch(NUM_TIMERS)-1:0]     ch_clr,
    output logic [clamp_ch(NUM_TIMERS)-1:0]     int_status,
    output logic                                glb_en,
    output logic                                legacy_rt
);
    localparam int          NCH = clamp_ch(NUM_TIMERS);
    localparam logic [63:0] CAP = cap_word(NCH, VENDOR_ID, PERIOD_FS);

    dec_t           dec;
    logic [1:0]     ctrl_q;
    logic [1:0]     ctrl_nxt;
    logic           wr_ctrl;
    logic           wr_stat;
    logic           wr_cnt;
    logic           run_rise;
    logic           run_fall;
    logic [NCH-1:0] clr_req;
    logic [63:0]    cnt_view;
    logic [63:0]    cnt_live;
    logic [63:0]    cnt_hold;
    logic [63:0]    rd_mux;

    evt_addr_dec #(.NCH(NCH)) u_dec (
        .addr (req_addr),
        .dec  (dec)
    );

    assign wr_ctrl = req_wr && (dec.sel == RG_CTRL);
    assign wr_stat = req_wr && (dec.sel == RG_STAT);
    assign wr_cnt  = req_wr && (dec.sel == RG_CNT);

    // Only the low half carries writable control bits.
    assign ctrl_nxt = (wr_ctrl && !dec.hi) ? req_wdata[1:0] : ctrl_q;
    assign run_rise = !ctrl_q[0] &&  ctrl_nxt[0];
    assign run_fall =  ctrl_q[0] && !ctrl_nxt[0];

    always_ff @(posedge clk) begin
        if (rst) ctrl_q <= 2'b00;
        else     ctrl_q <= ctrl_nxt;
    end

    assign glb_en    = ctrl_q[0];
    assign legacy_rt = ctrl_q[1];

    evt_main_ctr u_ctr (
        .clk      (clk),
        .rst      (rst),
        .run      (ctrl_q[0]),
        .run_rise (run_rise),
        .run_fall (run_fall),
        .tick_en  (tick_en),
        .ld       (wr_cnt),
        .ld_hi    (dec.hi),
        .ld_wide  (req_wide),
        .ld_data  (req_wdata),
        .cnt_view (cnt_view),
        .cnt_live (cnt_live),
        .cnt_hold (cnt_hold)
    );

    assign clr_req = (wr_stat && !dec.hi) ? req_wdata[NCH-1:0] : '0;

    evt_stat #(.NCH(NCH)) u_stat (
        .clk       (clk),
        .rst       (rst),
        .clr_req   (clr_req),
        .fire      (ch_fire),
        .status    (int_status),
        .clr_pulse (ch_clr)
    );

    assign ch_idx = dec.ch_idx;
    assign ch_off = dec.ch_off;
    assign ch_wr  = req_wr && (dec.sel == RG_CHAN) && dec.ch_ok;
    assign ch_rd  = req_rd && (dec.sel == RG_CHAN) && dec.ch_ok;

    always_comb begin
        case (dec.sel)
            RG_CAP:  rd_mux = read_half(CAP, dec.hi, req_wide);
            RG_CTRL: rd_mux = read_half({62'd0, ctrl_q}, dec.hi, req_wide);
            RG_STAT: rd_mux = read_half(64'(int_status), dec.hi, req_wide);
            RG_CNT:  rd_mux = read_half(cnt_view, dec.hi, req_wide);
            RG_CHAN: rd_mux = dec.ch_ok ? ch_rdata : 64'd0;
            default: rd_mux = 64'd0;
        endcase
    end

    assign req_rdata = req_rd ? rd_mux : 64'd0;
endmodule

// File: rtl/evt_regblk_chk.sv
module evt_regblk_chk #(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst,
    input logic           tick_en,
    input logic           glb_en,
    input logic           req_wr,
    input logic [9:0]     req_addr,
    input logic [NCH-1:0] ch_fire,
    input logic [NCH-1:0] ch_clr,
    input logic [NCH-1:0] int_status,
    input logic           ch_wr,
    input logic           ch_rd,
    input logic [4:0]     ch_idx,
    input logic [63:0]    cnt_live,
    input logic [63:0]    cnt_hold
);
    logic cnt_wr_seen;
    assign cnt_wr_seen = req_wr && (req_addr[9:3] == 7'h1E) && (req_addr[1:0] == 2'b00);

    // R3
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        glb_en && tick_en |=> cnt_live == $past(cnt_live) + 64'd1);

    // R3
    cnt_pause_chk: assert property (@(posedge clk) disable iff (rst)
        glb_en && !tick_en |=> $stable(cnt_live));

    // R5
    halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !glb_en && !cnt_wr_seen |=> $stable(cnt_hold));

    // R6
    clr_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (|ch_clr) |=> (int_status & $past(ch_clr)) == '0);

    // R6
    fire_set_chk: assert property (@(posedge clk) disable iff (rst)
        (|ch_fire) |=> (int_status & $past(ch_fire)) == $past(ch_fire));

    // R10
    oob_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (ch_wr || ch_rd) |-> ({1'b0, ch_idx} < 6'(NCH)));
endmodule

bind evt_regblk evt_regblk_chk #(.NCH(NCH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .tick_en    (tick_en),
    .glb_en     (glb_en),
    .req_wr     (req_wr),
    .req_addr   (req_addr),
    .ch_fire    (ch_fire),
    .ch_clr     (ch_clr),
    .int_status (int_status),
    .ch_wr      (ch_wr),
    .ch_rd      (ch_rd),
    .ch_idx     (ch_idx),
    .cnt_live   (cnt_live),
    .cnt_hold   (cnt_hold)
);

// File: tb/tb_evt_regblk.sv
module tb_evt_regblk;
    localparam int          CLK_NS = 10;
    localparam logic [15:0] VID    = 16'h1E5A;
    localparam logic [31:0] PFS    = 32'd10000000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic        req_wr = 1'b0;
    logic        req_rd = 1'b0;
    logic [9:0]  req_addr = '0;
    logic        req_wide = 1'b0;
    logic [63:0] req_wdata = '0;
    logic [63:0] req_rdata;
    logic [3:0]  ch_fire = '0;
    logic [63:0] ch_rdata = 64'hC0DE_0000_ABCD_1234;
    logic [4:0]  ch_idx, ch_off;
    logic        ch_wr, ch_rd;
    logic [3:0]  ch_clr, int_status;
    logic        glb_en, legacy_rt;

    always #(CLK_NS/2) clk = ~clk;

    evt_regblk #(.NUM_TIMERS(4), .VENDOR_ID(VID), .PERIOD_FS(PFS)) dut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .req_wr(req_wr), .req_rd(req_rd),
        .req_addr(req_addr), .req_wide(req_wide), .req_wdata(req_wdata),
        .req_rdata(req_rdata), .ch_fire(ch_fire), .ch_rdata(ch_rdata),
        .ch_idx(ch_idx), .ch_off(ch_off), .ch_wr(ch_wr), .ch_rd(ch_rd),
        .ch_clr(ch_clr), .int_status(int_status), .glb_en(glb_en), .legacy_rt(legacy_rt)
    );

    // Clamp instances (R13)
    logic [63:0] s_rd, b_rd;
    logic [4:0]  s_idx, s_off, b_idx, b_off;
    logic        s_wr, s_rdv, s_en, s_lg, b_wr, b_rdv, b_en, b_lg;
    logic [2:0]  s_clr, s_st;
    logic [31:0] b_clr, b_st;

    evt_regblk #(.NUM_TIMERS(1), .VENDOR_ID(VID), .PERIOD_FS(PFS)) dut_small (
        .clk(clk), .rst(rst), .tick_en(1'b0), .req_wr(1'b0), .req_rd(1'b1),
        .req_addr(10'h000), .req_wide(1'b1), .req_wdata(64'd0), .req_rdata(s_rd),
        .ch_fire(3'd0), .ch_rdata(64'd0), .ch_idx(s_idx), .ch_off(s_off),
        .ch_wr(s_wr), .ch_rd(s_rdv), .ch_clr(s_clr), .int_status(s_st),
        .glb_en(s_en), .legacy_rt(s_lg)
    );

    evt_regblk #(.NUM_TIMERS(40), .VENDOR_ID(VID), .PERIOD_FS(PFS)) dut_big (
        .clk(clk), .rst(rst), .tick_en(1'b0), .req_wr(1'b0), .req_rd(1'b1),
        .req_addr(10'h000), .req_wide(1'b1), .req_wdata(64'd0), .req_rdata(b_rd),
        .ch_fire(32'd0), .ch_rdata(64'd0), .ch_idx(b_idx), .ch_off(b_off),
        .ch_wr(b_wr), .ch_rd(b_rdv), .ch_clr(b_clr), .int_status(b_st),
        .glb_en(b_en), .legacy_rt(b_lg)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // Reference model state
    bit          m_run, m_leg;
    logic [63:0] m_live, m_frozen;
    logic [3:0]  m_stat;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] cap_exp(input int n);
        return {PFS, VID, 1'b1, 1'b0, 1'b1, 5'(n - 1), 8'd1};
    endfunction

    function automatic logic [63:0] m_read(input logic [9:0] a, input logic wide);
        int          ia;
        logic [63:0] v;
        ia = int'(a);
        if (ia >= 256) begin
            if ((ia - 256) / 32 < 4) return ch_rdata;
            return 64'd0;
        end
        case (ia & ~4)
            0:       v = cap_exp(4);
            16:      v = {62'd0, m_leg, m_run};
            32:      v = {60'd0, m_stat};
            240:     v = m_run ? m_live : m_frozen;
            default: v = 64'd0;
        endcase
        if (a[2]) v = v >> 32;
        if (!wide) v = v & 64'h0000_0000_FFFF_FFFF;
        return v;
    endfunction

    function automatic logic [63:0] put(input logic [63:0] o, input logic [63:0] w,
                                        input logic hi, input logic wide);
        logic [63:0] r;
        r = o;
        if (hi) r[63:32] = w[31:0];
        else if (wide) r = w;
        else r[31:0] = w[31:0];
        return r;
    endfunction

    task automatic cyc(input logic wr, input logic rd, input logic [9:0] a,
                       input logic wide, input logic [63:0] wd,
                       input logic tk, input logic [3:0] fr);
        int          ia, base, slot;
        logic [3:0]  clr;
        logic [63:0] inc;
        bit          nr, nl;
        @(negedge clk);
        req_wr = wr; req_rd = rd; req_addr = a; req_wide = wide;
        req_wdata = wd; tick_en = tk; ch_fire = fr;
        #1;
        ia   = int'(a);
        base = ia & ~4;
        slot = (ia - 256) / 32;
        // per-clock comparisons against the model
        chk("R2 glb_en", 64'(glb_en), 64'(m_run));
        chk("R2 legacy_rt", 64'(legacy_rt), 64'(m_leg));
        chk("R6 int_status", 64'(int_status), 64'(m_stat));
        chk("R12 read data", req_rdata, rd ? m_read(a, wide) : 64'd0);
        clr = (wr && ia < 256 && base == 32 && !a[2]) ? (wd[3:0] & m_stat & ~fr) : 4'd0;
        chk("R7 ch_clr", 64'(ch_clr), 64'(clr));
        chk("R10 ch_wr", 64'(ch_wr), 64'(wr && ia >= 256 && slot < 4));
        chk("R10 ch_rd", 64'(ch_rd), 64'(rd && ia >= 256 && slot < 4));
        if (ia >= 256 && slot < 4 && (wr || rd)) begin
            chk("R9 ch_idx", 64'(ch_idx), 64'(slot));
            chk("R9 ch_off", 64'(ch_off), 64'(ia % 32));
        end
        @(posedge clk);
        inc = (m_run && tk) ? 64'd1 : 64'd0;
        if (wr && ia < 256 && base == 16) begin
            nr = m_run; nl = m_leg;
            if (!a[2]) begin nr = wd[0]; nl = wd[1]; end
            if (!m_run && nr) m_live = m_frozen;
            else begin
                m_live = m_live + inc;
                if (m_run && !nr) m_frozen = m_live;
            end
            m_run = nr; m_leg = nl;
        end else begin
            m_live = m_live + inc;
            if (wr && ia < 256 && base == 240) m_frozen = put(m_frozen, wd, a[2], wide);
        end
        m_stat = (m_stat & ~clr) | fr;
    endtask

    task automatic rd(input logic [9:0] a, input logic wide, input logic tk);
        cyc(1'b0, 1'b1, a, wide, 64'd0, tk, 4'd0);
    endtask

    task automatic wr(input logic [9:0] a, input logic wide, input logic [63:0] d);
        cyc(1'b1, 1'b0, a, wide, d, 1'b0, 4'd0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        m_run = 0; m_leg = 0; m_live = '0; m_frozen = '0; m_stat = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R12 reset state
        rd(10'h010, 1'b1, 1'b0);
        rd(10'h0F0, 1'b1, 1'b0);
        rd(10'h020, 1'b1, 1'b0);

        // R1 capability, read-only
        @(negedge clk); req_rd = 1; req_addr = 10'h000; req_wide = 1; req_wr = 0; #1;
        chk("R1 cap literal", req_rdata, 64'h0098_9680_1E5A_A301);
        wr(10'h000, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(10'h000, 1'b1, 1'b0);
        rd(10'h004, 1'b0, 1'b0);

        // R13 clamp
        chk("R13 small count field", 64'(s_rd[12:8]), 64'd2);
        chk("R13 big count field", 64'(b_rd[12:8]), 64'd31);

        // R2 writable bits only
        wr(10'h010, 1'b1, 64'hFFFF_FFFF_FFFF_FFFE);
        rd(10'h010, 1'b1, 1'b0);
        wr(10'h014, 1'b0, 64'h0000_0000_FFFF_FFFF);
        rd(10'h010, 1'b1, 1'b0);
        wr(10'h010, 1'b1, 64'd0);

        // R8 half writes of the halted counter, R5 load
        wr(10'h0F0, 1'b0, 64'hAAAA_AAAA_0000_0100);
        wr(10'h0F4, 1'b0, 64'h1111_1111_0000_0005);
        rd(10'h0F4, 1'b0, 1'b0);
        rd(10'h0F0, 1'b1, 1'b1);
        @(negedge clk); req_wr = 0; req_rd = 1; req_addr = 10'h0F0; req_wide = 1; #1;
        chk("R8 counter merge", req_rdata, 64'h0000_0005_0000_0100);

        // R3 run with mixed ticks
        wr(10'h010, 1'b0, 64'd1);
        for (int i = 0; i < 12; i++) rd(10'h0F0, 1'b1, (i % 3) != 1);
        rd(10'h0F4, 1'b0, 1'b1);

        // R4 write while running, with ticks in the same cycle
        cyc(1'b1, 1'b0, 10'h0F0, 1'b1, 64'd0, 1'b1, 4'd0);
        for (int i = 0; i < 4; i++) rd(10'h0F0, 1'b1, 1'b1);
        cyc(1'b1, 1'b0, 10'h010, 1'b0, 64'd0, 1'b1, 4'd0);

        // R5 frozen while halted
        for (int i = 0; i < 5; i++) rd(10'h0F0, 1'b1, 1'b1);
        wr(10'h0F4, 1'b1, 64'h0000_0000_0000_0009);
        wr(10'h010, 1'b0, 64'd1);
        for (int i = 0; i < 3; i++) rd(10'h0F0, 1'b1, 1'b1);
        wr(10'h010, 1'b0, 64'd0);

        // R6 status set and clear
        cyc(1'b0, 1'b0, 10'h000, 1'b0, 64'd0, 1'b0, 4'b0101);
        rd(10'h020, 1'b1, 1'b0);
        wr(10'h020, 1'b1, 64'hFFFF_FFFF_FFFF_0004);
        wr(10'h020, 1'b1, 64'd0);
        wr(10'h024, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(10'h020, 1'b0, 1'b0);

        // R7 fire and clear in the same cycle
        cyc(1'b0, 1'b0, 10'h000, 1'b0, 64'd0, 1'b0, 4'b1000);
        cyc(1'b1, 1'b0, 10'h020, 1'b0, 64'h0000_0000_0000_0009, 1'b0, 4'b0001);
        @(negedge clk); req_wr = 0; req_rd = 1; req_addr = 10'h020; req_wide = 0; ch_fire = 0; #1;
        chk("R7 bit0 kept", req_rdata, 64'h1);

        // R8 wide access at offset 4
        wr(10'h0F4, 1'b1, 64'hDEAD_BEEF_0000_0033);
        rd(10'h0F0, 1'b1, 1'b0);
        rd(10'h0F4, 1'b1, 1'b0);

        // R9 channel decode
        rd(10'h148, 1'b1, 1'b0);
        ch_rdata = 64'h1357_9BDF_2468_ACE0;
        wr(10'h16C, 1'b0, 64'h55);
        rd(10'h11C, 1'b0, 1'b0);

        // R10 past the channel count
        rd(10'h180, 1'b1, 1'b0);
        wr(10'h3FC, 1'b0, 64'h1);
        rd(10'h3FC, 1'b1, 1'b0);

        // R11 reserved offsets
        wr(10'h030, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(10'h030, 1'b1, 1'b0);
        wr(10'h0F8, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(10'h0F8, 1'b1, 1'b0);
        rd(10'h011, 1'b0, 1'b0);
        rd(10'h010, 1'b1, 1'b0);
        rd(10'h0F0, 1'b1, 1'b0);

        // R12 reset again after activity
        @(negedge clk); rst = 1; req_wr = 0; req_rd = 0; ch_fire = 0;
        repeat (2) @(posedge clk);
        @(negedge clk); rst = 0;
        m_run = 0; m_leg = 0; m_live = '0; m_frozen = '0; m_stat = '0;
        rd(10'h0F0, 1'b1, 1'b0);
        rd(10'h020, 1'b1, 1'b0);

        @(negedge clk);
        req_rd = 0;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule